// File: doc/BRIEF.md
# Collision-Detect Bus Access Node

This block is one node's access controller for a shared serial line that has no central arbiter. When a request arrives, the node captures the word and waits until the bus-busy sense input shows the line free. It then drives the word onto the line one bit per cycle, most significant bit first. The line is wired-AND: a node that drives a 1 while another node drives a 0 reads back a 0. On every cycle it drives, the node compares the value it reads back from the line with the value it drove.

Any mismatch means a second node started at the same moment. The node then releases the line at once and waits a pseudo-random number of cycles before it senses the bus again. The wait is drawn from a free-running LFSR and masked to a window. The window doubles on each further collision of the same request, up to a cap. After a set number of colliding attempts, the node gives up and reports failure. A finished transfer gives a one-cycle done pulse.

Top module: `bus_cd_node`

## Requirements
- R1: While reset is low, and in the first cycle after it, `drv_en`, `tx_done`, `tx_coll` and `tx_fail` are all 0.
- R2: After a request, `drv_en` stays 0 for as long as `bus_busy` is 1. It rises in the cycle after the first clock edge that sees `bus_busy` at 0.
- R3: A transfer keeps `drv_en` high for exactly WORD_W cycles. `drv_bit` carries the captured word most significant bit first, one bit per cycle.
- R4: In the cycle after the last bit, `tx_done` is 1 for one cycle and `drv_en` is 0. `tx_done` and `tx_coll` are never high together.
- R5: A cycle with `drv_en` high and `bus_line` different from `drv_bit` is a collision. In the next cycle `drv_en` is 0 and `tx_coll` is 1 for one cycle.
- R6: After the k-th collision of a request (k = 1, 2, ...), `drv_en` stays low for between 2 and M+2 cycles before the node drives again. M = 2^min(BASE_WIN_LOG+k-1, MAX_WIN_LOG) - 1. With the defaults the masks are 3, 7, 15, 15.
- R7: The MAX_TRIES-th collision of a request pulses `tx_fail` together with `tx_coll`. The node then stays off the line until a new request arrives.
- R8: A new request restarts the attempt count and the backoff window. After one collision, the gap is again bounded by the first-window mask, and the transfer can still complete with `tx_done`.
- R9: `tx_req` and `tx_word` are ignored while a request is in progress. The bits driven are those of the word captured at the accepted request.
- R10: A mismatch on `bus_line` while `drv_en` is 0 raises no `tx_coll` and starts no drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_req | input | 1 | One-cycle request to send `tx_word` (taken only when the node is idle) |
| tx_word | input | WORD_W | Word to transmit |
| bus_busy | input | 1 | High while the shared line is in use |
| bus_line | input | 1 | Value read back from the shared line |
| drv_en | output | 1 | Node drives the line |
| drv_bit | output | 1 | Bit driven when `drv_en` is high |
| tx_done | output | 1 | One-cycle pulse: word sent without collision |
| tx_coll | output | 1 | One-cycle pulse: collision detected, attempt aborted |
| tx_fail | output | 1 | One-cycle pulse: attempt limit reached, request dropped |

## Verification
The bench builds the node with its defaults: an 8-bit word, a backoff window from 2 to 4 mask bits, and five attempts. With a permanently jammed line, a single request therefore runs through every window size. The third and fourth collisions both sit at the cap, and the fifth reaches the failure path, all within a few hundred cycles. The bench bounds every backoff gap by the window for that collision number. Because the seed is fixed, the random draws are repeatable, so the bounds are checked against actual gaps rather than model values.

// File: rtl/bus_cd_pkg.sv
// Shared types for the collision-detect bus node.
// Assumes nothing beyond a standard SystemVerilog compile order.
package bus_cd_pkg;

    // Node sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,   // no request held
        ST_SENSE,  // request held, waiting for a free line
        ST_SEND,   // driving bits and comparing read-back
        ST_WAIT    // random backoff after a collision
    } node_st_e;

endpackage

// File: rtl/bus_cd_lfsr.sv
// Free-running Fibonacci LFSR that supplies backoff draws.
// Assumes TAPS describes a maximal polynomial and SEED is nonzero.
module bus_cd_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   TAPS = 16'hB400,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    logic fb;

    // Feedback is the parity of the tapped bits
    assign fb = ^(state & TAPS);

    // Advance one step every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], fb};
    end

endmodule

// File: rtl/bus_cd_backoff.sv
// Backoff window and countdown. On load it takes a random draw masked to
// 2^exp-1 and widens the window by one bit up to MAX_LOG. Clear restores
// the base window. Assumes 1 <= BASE_LOG <= MAX_LOG.
module bus_cd_backoff #(
    parameter int BASE_LOG = 2,
    parameter int MAX_LOG  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic               tick,
    input  logic [MAX_LOG-1:0] rnd,
    output logic               expired
);

    localparam int EXP_W = $clog2(MAX_LOG + 1);

    logic [EXP_W-1:0]   exp_q;
    logic [MAX_LOG-1:0] cnt_q;
    logic [MAX_LOG-1:0] mask;

    // Thermometer mask: bit i set when i is below the window exponent
    for (genvar gi = 0; gi < MAX_LOG; gi++) begin : g_mask
        assign mask[gi] = (exp_q > EXP_W'(gi));
    end

    // Window exponent and countdown register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            exp_q <= EXP_W'(BASE_LOG);
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= rnd & mask;
            if (exp_q < EXP_W'(MAX_LOG)) exp_q <= exp_q + 1'b1;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bus_cd_shifter.sv
// Parallel-load shift register that serialises a word MSB first and flags
// the final bit. Assumes W >= 2.
module bus_cd_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         bit_out,
    output logic         last
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] idx_q;

    // Load a fresh word or move to the next bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= word;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_out = sr_q[W-1];
    assign last    = (idx_q == CW'(W - 1));

endmodule

// File: rtl/bus_cd_node.sv
// Collision-detect access node for a shared wired-AND serial line.
// Captures a word on request, waits for a free line, drives the word MSB
// first and aborts on any read-back mismatch. It retries after a random
// backoff whose window grows per collision, and fails after MAX_TRIES
// attempts. Assumes bus_busy and bus_line are synchronous to clk and
// LFSR_W >= MAX_WIN_LOG.
module bus_cd_node #(
    parameter int                 WORD_W       = 8,
    parameter int                 LFSR_W       = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS    = 16'hB400,
    parameter logic [LFSR_W-1:0]  LFSR_SEED    = 16'hACE1,
    parameter int                 BASE_WIN_LOG = 2,
    parameter int                 MAX_WIN_LOG  = 4,
    parameter int                 MAX_TRIES    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_req,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              bus_busy,
    input  logic              bus_line,
    output logic              drv_en,
    output logic              drv_bit,
    output logic              tx_done,
    output logic              tx_coll,
    output logic              tx_fail
);

    import bus_cd_pkg::*;

    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    node_st_e          st_q;
    logic [WORD_W-1:0] word_q;
    logic [TRY_W-1:0]  tries_q;
    logic              done_q, coll_q, fail_q;
    logic [LFSR_W-1:0] lfsr_w;
    logic              accept, start, collide, final_try, last_bit, expired;

    // Request accepted only from idle
    assign accept    = (st_q == ST_IDLE) && tx_req;
    // Line seen free while a request is held
    assign start     = (st_q == ST_SENSE) && !bus_busy;
    // Read-back differs from the bit being driven
    assign collide   = (st_q == ST_SEND) && (bus_line != drv_bit);
    // This collision uses up the last attempt
    assign final_try = (tries_q == TRY_W'(MAX_TRIES - 1));

    bus_cd_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_w)
    );

    bus_cd_backoff #(
        .BASE_LOG (BASE_WIN_LOG),
        .MAX_LOG  (MAX_WIN_LOG)
    ) backoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .load    (collide && !final_try),
        .tick    (st_q == ST_WAIT),
        .rnd     (lfsr_w[MAX_WIN_LOG-1:0]),
        .expired (expired)
    );

    bus_cd_shifter #(
        .W (WORD_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .word    (word_q),
        .shift   ((st_q == ST_SEND) && !collide),
        .bit_out (drv_bit),
        .last    (last_bit)
    );

    // Sequencer: capture, sense, send, back off, count attempts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            word_q  <= '0;
            tries_q <= '0;
            done_q  <= 1'b0;
            coll_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            coll_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (tx_req) begin
                        word_q  <= tx_word;
                        tries_q <= '0;
                        st_q    <= ST_SENSE;
                    end
                end
                ST_SENSE: begin
                    if (!bus_busy) st_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (collide) begin
                        coll_q <= 1'b1;
                        if (final_try) begin
                            fail_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            st_q    <= ST_WAIT;
                        end
                    end else if (last_bit) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (expired) st_q <= ST_SENSE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign drv_en  = (st_q == ST_SEND);
    assign tx_done = done_q;
    assign tx_coll = coll_q;
    assign tx_fail = fail_q;

endmodule

// File: rtl/bus_cd_node_chk.sv
// Property checker for bus_cd_node, attached by bind.
// Observes the top-level ports only.
module bus_cd_node_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_req,
    input logic [WORD_W-1:0] tx_word,
    input logic              bus_busy,
    input logic              bus_line,
    input logic              drv_en,
    input logic              drv_bit,
    input logic              tx_done,
    input logic              tx_coll,
    input logic              tx_fail
);

    // R2: drive starts only after an edge that saw a free line
    p_free_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(!bus_busy));

    // R4: done follows a driving cycle and the line is released
    p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!drv_en && $past(drv_en)));

    // R4: done and collision never pulse together
    p_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_coll));

    // R5: a read-back mismatch aborts and flags a collision
    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && (bus_line != drv_bit)) |=> (!drv_en && tx_coll));

    // R7: failure is always reported with its collision
    p_fail_coll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |-> tx_coll);

    // R10: no collision flag unless the node was driving
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_coll |-> $past(drv_en));

endmodule

bind bus_cd_node bus_cd_node_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_req   (tx_req),
    .tx_word  (tx_word),
    .bus_busy (bus_busy),
    .bus_line (bus_line),
    .drv_en   (drv_en),
    .drv_bit  (drv_bit),
    .tx_done  (tx_done),
    .tx_coll  (tx_coll),
    .tx_fail  (tx_fail)
);

// File: tb/bus_cd_node_tb_top.sv
// Self-checking bench for bus_cd_node. The shared line is modelled as
// wired-AND; 'jam' stands for another node holding the line low.
module bus_cd_node_tb_top;

    localparam int W     = 8;
    localparam int TRIES = 5;
    localparam int NVEC  = 5;
    // {word, cycles of busy line before sending}
    localparam logic [15:0] VECS [0:NVEC-1] =
        '{16'hA500, 16'h3C03, 16'hFF01, 16'h0005, 16'h8102};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_req = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         bus_busy = 1'b0;
    logic         jam = 1'b0;
    logic         bus_line;
    logic         drv_en, drv_bit, tx_done, tx_coll, tx_fail;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    assign bus_line = (drv_en ? drv_bit : 1'b1) & ~jam;

    bus_cd_node dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (tx_req),
        .tx_word  (tx_word),
        .bus_busy (bus_busy),
        .bus_line (bus_line),
        .drv_en   (drv_en),
        .drv_bit  (drv_bit),
        .tx_done  (tx_done),
        .tx_coll  (tx_coll),
        .tx_fail  (tx_fail)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", rq, act, expv);
        end
    endtask

    function automatic int win_mask(input int k);
        int e = 2 + k - 1;
        if (e > 4) e = 4;
        return (1 << e) - 1;
    endfunction

    // Send one word, optional busy hold and optional mid-transfer request
    task automatic send_word(input logic [W-1:0] w, input int busy_n, input bit poke);
        logic [W-1:0] got = '0;
        @(negedge clk);
        tx_word = w; tx_req = 1'b1; bus_busy = (busy_n > 0);
        @(negedge clk);
        tx_req = 1'b0;
        for (int k = 0; k < busy_n; k++) begin
            @(negedge clk);
            chk(drv_en == 1'b0, "R2 hold while busy", drv_en, 0);
        end
        bus_busy = 1'b0;
        @(negedge clk);
        chk(drv_en == 1'b1, "R2 start on free line", drv_en, 1);
        for (int i = 0; i < W; i++) begin
            got[W-1-i] = drv_bit;
            if (!drv_en) chk(1'b0, "R3 drive width", i, W);
            if (poke && i == 2) begin tx_req = 1'b1; tx_word = ~w; end
            @(negedge clk);
            tx_req = 1'b0;
        end
        chk(got == w, poke ? "R9 word kept" : "R3 bit order", got, w);
        chk(tx_done && !drv_en, "R4 done pulse", {tx_done, drv_en}, 2);
        @(negedge clk);
        chk(!tx_done && !drv_en, "R4 single done", {tx_done, drv_en}, 0);
    endtask

    // Wait for drive; returns number of low cycles seen
    task automatic wait_drive(output int g);
        g = 0;
        while (!drv_en && g < 200) begin
            @(negedge clk);
            g++;
        end
    endtask

    initial begin : main
        int g;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({drv_en, tx_done, tx_coll, tx_fail} == 4'b0, "R1 in reset",
            {drv_en, tx_done, tx_coll, tx_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({drv_en, tx_done, tx_coll, tx_fail} == 4'b0, "R1 after reset",
            {drv_en, tx_done, tx_coll, tx_fail}, 0);

        // R2 R3 R4: table walk
        for (int v = 0; v < NVEC; v++)
            send_word(VECS[v][15:8], int'(VECS[v][7:0]), 1'b0);

        // R9: request during transfer is ignored
        send_word(8'h96, 0, 1'b1);
        repeat (4) @(negedge clk);
        chk(drv_en == 1'b0, "R9 no extra transfer", drv_en, 0);

        // R10: line pulled low while not driving
        jam = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!tx_coll && !drv_en, "R10 quiet when idle", {tx_coll, drv_en}, 0);
        end

        // R5 R6 R7: jammed line through every attempt
        tx_word = 8'hA5; tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        wait_drive(g);
        for (int a = 1; a <= TRIES; a++) begin
            @(negedge clk);
            chk(!drv_en && tx_coll, "R5 abort on mismatch", {drv_en, tx_coll}, 1);
            chk(tx_fail == (a == TRIES), "R7 fail on last try", tx_fail, a == TRIES);
            if (a < TRIES) begin
                g = 1;
                @(negedge clk);
                begin
                    int more;
                    wait_drive(more);
                    g += more;
                end
                chk(g >= 2 && g <= win_mask(a) + 2, "R6 backoff window", g, win_mask(a) + 2);
            end
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (drv_en) chk(1'b0, "R7 silent after fail", drv_en, 0);
        end
        chk(drv_en == 1'b0, "R7 silent after fail", drv_en, 0);

        // R8: new request restarts window and can complete
        tx_word = 8'hC3; tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        wait_drive(g);
        @(negedge clk);
        jam = 1'b0;
        chk(tx_coll && !tx_fail, "R8 first collision no fail", {tx_coll, tx_fail}, 2);
        g = 1;
        @(negedge clk);
        begin
            int more;
            wait_drive(more);
            g += more;
        end
        chk(g >= 2 && g <= win_mask(1) + 2, "R8 window reset", g, win_mask(1) + 2);
        repeat (W) @(negedge clk);
        chk(tx_done == 1'b1, "R8 retry completes", tx_done, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule